// File: doc/BRIEF.md
# Shadow Return Address Stack

This block keeps a private, hardware-only copy of function return addresses next to the processor's commit stage. The block sees committed calls and committed returns, in program order. Each committed call pushes the link-register value onto the private stack. Each committed return pops the top copy and compares it with the link-register value that the return is about to use. A difference means the in-memory return address was tampered with, and the block raises a one-cycle mismatch exception. A call that finds the stack full raises an overflow exception and is dropped. A return that finds it empty raises an underflow exception. The exception handler can then spill the contents to memory or refill them.

Ordinary loads and stores from user code cannot reach the storage. Privileged software reaches it through a small mapped window. The window holds a depth register and an indexed region of entries, so a context switch can save and restore the whole stack with plain loads and stores. Any window access made without privilege reads as zero, has no effect, and raises an access-violation pulse.

Top module: `shadow_ret_stack`

## Requirements
- R1: A cycle with `call_commit` high and no return writes `link_addr` into entry index equal to the current depth and increments the depth by one, when the depth is below DEPTH.
- R2: A cycle with `ret_commit` high, a non-zero depth and `link_addr` equal to the top entry (index depth-1) decrements the depth by one and raises no exception.
- R3: A return whose `link_addr` differs from the top entry pops the entry as in R2 and drives `mismatch_exc` high in the cycle after the commit edge.
- R4: A call while the depth equals DEPTH drives `overflow_exc` high in the cycle after the edge. The depth and every entry stay unchanged.
- R5: A return while the depth is zero drives `underflow_exc` high in the cycle after the edge. No compare is made, so `mismatch_exc` stays low, and the depth stays zero.
- R6: When a call and a return commit in the same cycle, the return is handled first (pop and compare, or underflow) and the push second. With a non-zero depth, the depth is unchanged and the top entry becomes `link_addr`. With zero depth, an underflow is raised and the depth becomes 1. A full stack raises no overflow in this case.
- R7: A privileged access with `mmio_addr` MSB = 0 targets the depth register. A read returns the depth zero-extended. A write sets the depth to `mmio_wdata`, clamped to DEPTH, and takes priority over commit strobes in the same cycle.
- R8: A privileged access with `mmio_addr` MSB = 1 targets entry `mmio_addr[IDX-1:0]`, where entry 0 is the oldest push. Reads return the stored value and writes replace it. A push to the same index in the same cycle takes priority over the window write.
- R9: An access with `mmio_sel` high and `mmio_priv` low returns zero, changes neither the depth nor any entry, and drives `access_viol` high for exactly the next cycle.
- R10: `mismatch_exc`, `overflow_exc`, `underflow_exc`, `access_viol` and `mmio_rdata` are registered. Each reflects only the inputs of the preceding edge and returns to zero one cycle later unless it is retriggered. At most one of the three exceptions is high at a time.
- R11: After reset the depth is zero, and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_commit | input | 1 | A call instruction committed this cycle |
| ret_commit | input | 1 | A return instruction committed this cycle |
| link_addr | input | W | Link-register value at commit |
| mismatch_exc | output | 1 | Return address differed from the shadow copy |
| overflow_exc | output | 1 | Push was refused because the stack was full |
| underflow_exc | output | 1 | Pop was attempted on an empty stack |
| mmio_sel | input | 1 | Window access strobe |
| mmio_we | input | 1 | Window access is a write |
| mmio_priv | input | 1 | Access is made in privileged mode |
| mmio_addr | input | $clog2(DEPTH)+1 | MSB selects the entry region; the low bits give the index |
| mmio_wdata | input | W | Window write data |
| mmio_rdata | output | W | Window read data, one cycle after the access |
| access_viol | output | 1 | Unprivileged window access was rejected |

## Verification
On every cycle the checker enforces the following:
- the depth never exceeds DEPTH;
- at most one exception is high at a time;
- a full-stack call holds the depth and raises an overflow;
- an empty-stack return keeps the depth at zero and raises only an underflow;
- a simultaneous call and return on a non-empty stack leaves the depth unchanged;
- every unprivileged access yields a violation and zero read data.

The content of the stored entries can only be shown by the bench's scenarios. These cover which value a return is compared against, the ordering inside a simultaneous call and return, the clamping of restored depths, and the proof that rejected writes left the entries intact. The bench runs them against a small configuration and sweeps every depth from empty to full.

// File: rtl/srs_pkg.sv
package srs_pkg;

   // Kind of window access decoded in a cycle
   typedef enum logic [1:0] {
      WIN_IDLE  = 2'd0,
      WIN_DEPTH = 2'd1,
      WIN_ENTRY = 2'd2,
      WIN_DENY  = 2'd3
   } win_op_e;

   // Exception flags produced by the commit logic
   typedef struct packed {
      logic mis;
      logic ovf;
      logic und;
   } exc_t;

endpackage

// File: rtl/srs_window.sv
module srs_window
   import srs_pkg::*;
#(
   parameter int W     = 32,
   parameter int DEPTH = 256,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             sel,
   input  logic             we,
   input  logic             priv,
   input  logic [IDX_W:0]   addr,
   input  logic [W-1:0]     wdata,
   output win_op_e          op,
   output logic             rd_req,
   output logic [IDX_W-1:0] idx,
   output logic             depth_wr,
   output logic [CNT_W-1:0] depth_val,
   output logic             ent_wr
);

   localparam logic [W-1:0] LIMIT_W = W'(DEPTH);

   always_comb begin
      if (!sel)
         op = WIN_IDLE;
      else if (!priv)
         op = WIN_DENY;
      else if (addr[IDX_W])
         op = WIN_ENTRY;
      else
         op = WIN_DEPTH;
   end

   assign idx      = addr[IDX_W-1:0];
   assign rd_req   = (op == WIN_DEPTH || op == WIN_ENTRY) && !we;
   assign depth_wr = (op == WIN_DEPTH) && we;
   assign ent_wr   = (op == WIN_ENTRY) && we;

   // A restored depth beyond capacity saturates at a full stack
   assign depth_val = (wdata > LIMIT_W) ? CNT_W'(DEPTH) : wdata[CNT_W-1:0];

endmodule

// File: rtl/srs_store.sv
module srs_store #(
   parameter int W              = 32,
   parameter int DEPTH          = 256,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_en,
   input  logic [IDX_W-1:0] push_idx,
   input  logic [W-1:0]     push_data,
   input  logic             win_en,
   input  logic [IDX_W-1:0] win_idx,
   input  logic [W-1:0]     win_data,
   input  logic [IDX_W-1:0] top_idx,
   output logic [W-1:0]     top_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [W-1:0]     rd_data
);

   logic [W-1:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic         hit_push;
      logic         hit_win;
      logic [W-1:0] ent_q;

      assign hit_push = push_en && (push_idx == IDX_W'(i));
      assign hit_win  = win_en && (win_idx == IDX_W'(i));

      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ent_q <= '0;
            else if (hit_push)
               ent_q <= push_data;
            else if (hit_win)
               ent_q <= win_data;
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (hit_push)
               ent_q <= push_data;
            else if (hit_win)
               ent_q <= win_data;
         end
      end

      assign mem[i] = ent_q;
   end

   assign top_data = mem[top_idx];
   assign rd_data  = mem[rd_idx];

endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
   import srs_pkg::*;
#(
   parameter int W     = 32,
   parameter int DEPTH = 256,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic [CNT_W-1:0] depth,
   input  logic             call,
   input  logic             ret,
   input  logic [W-1:0]     link,
   input  logic [W-1:0]     top_data,
   output logic [IDX_W-1:0] top_idx,
   output logic             push_en,
   output logic [IDX_W-1:0] push_idx,
   output logic [CNT_W-1:0] next_depth,
   output exc_t             exc
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   logic             empty;
   logic             pop_en;
   logic [CNT_W-1:0] mid_depth;
   logic [CNT_W-1:0] top_cnt;

   assign empty   = (depth == '0);
   assign top_cnt = depth - CNT_W'(1);
   assign top_idx = empty ? '0 : top_cnt[IDX_W-1:0];

   // The return is resolved first, then the call sees the reduced depth
   assign pop_en    = ret && !empty;
   assign mid_depth = pop_en ? top_cnt : depth;

   assign push_en    = call && (mid_depth != FULL);
   assign push_idx   = mid_depth[IDX_W-1:0];
   assign next_depth = push_en ? mid_depth + CNT_W'(1) : mid_depth;

   assign exc.und = ret && empty;
   assign exc.mis = pop_en && (top_data != link);
   assign exc.ovf = call && (mid_depth == FULL);

endmodule

// File: rtl/shadow_ret_stack.sv
module shadow_ret_stack
   import srs_pkg::*;
#(
   parameter int W              = 32,
   parameter int DEPTH          = 256,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     call_commit,
   input  logic                     ret_commit,
   input  logic [W-1:0]             link_addr,
   output logic                     mismatch_exc,
   output logic                     overflow_exc,
   output logic                     underflow_exc,
   input  logic                     mmio_sel,
   input  logic                     mmio_we,
   input  logic                     mmio_priv,
   input  logic [$clog2(DEPTH):0]   mmio_addr,
   input  logic [W-1:0]             mmio_wdata,
   output logic [W-1:0]             mmio_rdata,
   output logic                     access_viol
);

   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("shadow_ret_stack: DEPTH must be at least 2");
   end
   if ((1 << IDX_W) != DEPTH) begin : g_bad_pow2
      $error("shadow_ret_stack: DEPTH must be a power of two");
   end
   if (W <= CNT_W) begin : g_bad_width
      $error("shadow_ret_stack: W must exceed the depth counter width");
   end

   logic [CNT_W-1:0] depth_q;

   win_op_e          win_op;
   logic             win_rd;
   logic [IDX_W-1:0] win_idx;
   logic             win_depth_wr;
   logic [CNT_W-1:0] win_depth_val;
   logic             win_ent_wr;

   logic [IDX_W-1:0] top_idx;
   logic [W-1:0]     top_data;
   logic             push_en;
   logic [IDX_W-1:0] push_idx;
   logic [CNT_W-1:0] next_depth;
   exc_t             exc;
   logic [W-1:0]     ent_rd_data;

   srs_window #(.W(W), .DEPTH(DEPTH)) i_window (
      .sel       (mmio_sel),
      .we        (mmio_we),
      .priv      (mmio_priv),
      .addr      (mmio_addr),
      .wdata     (mmio_wdata),
      .op        (win_op),
      .rd_req    (win_rd),
      .idx       (win_idx),
      .depth_wr  (win_depth_wr),
      .depth_val (win_depth_val),
      .ent_wr    (win_ent_wr)
   );

   srs_ctrl #(.W(W), .DEPTH(DEPTH)) i_ctrl (
      .depth      (depth_q),
      .call       (call_commit),
      .ret        (ret_commit),
      .link       (link_addr),
      .top_data   (top_data),
      .top_idx    (top_idx),
      .push_en    (push_en),
      .push_idx   (push_idx),
      .next_depth (next_depth),
      .exc        (exc)
   );

   srs_store #(.W(W), .DEPTH(DEPTH), .CLEAR_ON_RESET(CLEAR_ON_RESET)) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_en   (push_en),
      .push_idx  (push_idx),
      .push_data (link_addr),
      .win_en    (win_ent_wr),
      .win_idx   (win_idx),
      .win_data  (mmio_wdata),
      .top_idx   (top_idx),
      .top_data  (top_data),
      .rd_idx    (win_idx),
      .rd_data   (ent_rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         depth_q <= '0;
      else if (win_depth_wr)
         depth_q <= win_depth_val;
      else
         depth_q <= next_depth;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mismatch_exc  <= 1'b0;
         overflow_exc  <= 1'b0;
         underflow_exc <= 1'b0;
         access_viol   <= 1'b0;
         mmio_rdata    <= '0;
      end else begin
         mismatch_exc  <= exc.mis;
         overflow_exc  <= exc.ovf;
         underflow_exc <= exc.und;
         access_viol   <= (win_op == WIN_DENY);
         if (win_rd && win_op == WIN_DEPTH)
            mmio_rdata <= W'(depth_q);
         else if (win_rd)
            mmio_rdata <= ent_rd_data;
         else
            mmio_rdata <= '0;
      end
   end

endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
   parameter int W     = 32,
   parameter int DEPTH = 256,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             call_commit,
   input logic             ret_commit,
   input logic             mismatch_exc,
   input logic             overflow_exc,
   input logic             underflow_exc,
   input logic             mmio_sel,
   input logic             mmio_we,
   input logic             mmio_priv,
   input logic [IDX_W:0]   mmio_addr,
   input logic [W-1:0]     mmio_rdata,
   input logic             access_viol,
   input logic [CNT_W-1:0] depth_q
);

   logic depth_write;
   assign depth_write = mmio_sel && mmio_we && mmio_priv && !mmio_addr[IDX_W];

   AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      depth_q <= CNT_W'(DEPTH)); // R7

   AST_ONE_EXCEPTION: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mismatch_exc, overflow_exc, underflow_exc})); // R10

   AST_OVERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (call_commit && !ret_commit && depth_q == CNT_W'(DEPTH) && !depth_write)
      |=> (overflow_exc && $stable(depth_q))); // R4

   AST_UNDERFLOW_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_commit && !call_commit && depth_q == '0 && !depth_write)
      |=> (underflow_exc && !mismatch_exc && depth_q == '0)); // R5

   AST_PAIR_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      (call_commit && ret_commit && depth_q != '0 && !depth_write)
      |=> ($stable(depth_q) && !overflow_exc && !underflow_exc)); // R6

   AST_USER_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (mmio_sel && !mmio_priv) |=> (access_viol && mmio_rdata == '0)); // R9

   AST_USER_NO_DEPTH_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (mmio_sel && !mmio_priv && !call_commit && !ret_commit) |=> $stable(depth_q)); // R9

   AST_VIOL_ONLY_USER: assert property (@(posedge clk) disable iff (!rst_n)
      !(mmio_sel && !mmio_priv) |=> !access_viol); // R10

endmodule

bind shadow_ret_stack srs_checker #(.W(W), .DEPTH(DEPTH)) i_srs_checker (.*);

// File: tb/test_shadow_ret_stack.sv
module test_shadow_ret_stack;

   localparam int W  = 16;
   localparam int D  = 8;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          call_commit = 1'b0;
   logic          ret_commit = 1'b0;
   logic [W-1:0]  link_addr = '0;
   logic          mismatch_exc, overflow_exc, underflow_exc;
   logic          mmio_sel = 1'b0, mmio_we = 1'b0, mmio_priv = 1'b0;
   logic [AW-1:0] mmio_addr = '0;
   logic [W-1:0]  mmio_wdata = '0;
   logic [W-1:0]  mmio_rdata;
   logic          access_viol;

   int total = 0;
   int bad = 0;

   logic [W-1:0] mm [D];
   int           md = 0;

   always #10 clk = ~clk;

   shadow_ret_stack #(.W(W), .DEPTH(D)) i_shadow_ret_stack (
      .clk, .rst_n, .call_commit, .ret_commit, .link_addr,
      .mismatch_exc, .overflow_exc, .underflow_exc,
      .mmio_sel, .mmio_we, .mmio_priv, .mmio_addr, .mmio_wdata,
      .mmio_rdata, .access_viol
   );

   function automatic logic [W-1:0] val(int i);
      return W'(16'h1000 + i * 16'h0123);
   endfunction

   task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // One clock with every input driven; expected outputs come from the model
   task automatic cyc(input logic c, input logic r, input logic [W-1:0] lk,
                      input logic s, input logic we, input logic pv,
                      input logic [AW-1:0] a, input logic [W-1:0] wd, input string tag);
      logic e_mis = 1'b0, e_ovf = 1'b0, e_und = 1'b0, e_viol;
      logic [W-1:0] e_rd = '0;
      int push_at = -1;
      e_viol = s && !pv;
      if (s && pv && !we)
         e_rd = a[AW-1] ? mm[a[AW-2:0]] : W'(md);
      if (r) begin
         if (md == 0) e_und = 1'b1;
         else begin
            if (mm[md-1] != lk) e_mis = 1'b1;
            md--;
         end
      end
      if (c) begin
         if (md == D) e_ovf = 1'b1;
         else begin
            mm[md] = lk; push_at = md; md++;
         end
      end
      if (s && pv && we) begin
         if (!a[AW-1]) md = (int'(wd) > D) ? D : int'(wd);
         else if (push_at != int'(a[AW-2:0])) mm[a[AW-2:0]] = wd;
      end
      @(negedge clk);
      call_commit = c; ret_commit = r; link_addr = lk;
      mmio_sel = s; mmio_we = we; mmio_priv = pv; mmio_addr = a; mmio_wdata = wd;
      @(posedge clk);
      #1;
      chk(tag, "mismatch_exc", W'(mismatch_exc), W'(e_mis));
      chk(tag, "overflow_exc", W'(overflow_exc), W'(e_ovf));
      chk(tag, "underflow_exc", W'(underflow_exc), W'(e_und));
      chk(tag, "access_viol", W'(access_viol), W'(e_viol));
      chk(tag, "mmio_rdata", mmio_rdata, e_rd);
   endtask

   task automatic idle(string tag);
      cyc(0, 0, '0, 0, 0, 0, '0, '0, tag);
   endtask
   task automatic do_call(logic [W-1:0] lk, string tag);
      cyc(1, 0, lk, 0, 0, 0, '0, '0, tag);
   endtask
   task automatic do_ret(logic [W-1:0] lk, string tag);
      cyc(0, 1, lk, 0, 0, 0, '0, '0, tag);
   endtask
   task automatic do_both(logic [W-1:0] lk, string tag);
      cyc(1, 1, lk, 0, 0, 0, '0, '0, tag);
   endtask
   task automatic win_wr(logic pv, logic [AW-1:0] a, logic [W-1:0] wd, string tag);
      cyc(0, 0, '0, 1, 1, pv, a, wd, tag);
   endtask
   task automatic win_rd(logic pv, logic [AW-1:0] a, string tag);
      cyc(0, 0, '0, 1, 0, pv, a, '0, tag);
   endtask

   // Read back depth and every entry through the privileged window
   task automatic read_all(string tag);
      win_rd(1, 4'h0, tag);
      for (int i = 0; i < D; i++) win_rd(1, AW'(8 + i), tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < D; i++) mm[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      // R11: outputs are zero while reset is applied
      chk("R11", "mismatch_exc", W'(mismatch_exc), '0);
      chk("R11", "overflow_exc", W'(overflow_exc), '0);
      chk("R11", "underflow_exc", W'(underflow_exc), '0);
      chk("R11", "access_viol", W'(access_viol), '0);
      chk("R11", "mmio_rdata", mmio_rdata, '0);
      @(negedge clk);
      rst_n = 1'b1;
      read_all("R11");

      // R1 and R7: push to full, watching the depth grow
      for (int i = 0; i < D; i++) begin
         do_call(val(i), "R1");
         win_rd(1, 4'h0, "R7");
      end
      // R8: entry i holds the i-th push
      read_all("R8");

      // R4 then R10: refused push, pulse lasts one cycle
      do_call(16'hDEAD, "R4");
      idle("R10");
      read_all("R4");

      // R2: matching returns
      for (int i = D - 1; i >= 4; i--) do_ret(val(i), "R2");
      win_rd(1, 4'h0, "R2");

      // R3: mismatching return still pops
      do_ret(16'hBEEF, "R3");
      idle("R10");
      win_rd(1, 4'h0, "R3");

      // R6: call and return together on a non-empty stack
      do_both(16'h5A5A, "R6");
      read_all("R6");
      do_both(16'h5A5A, "R6");
      // R2 and R5: drain completely, then pop once more
      while (md > 0) do_ret(mm[md-1], "R2");
      do_ret(16'h0001, "R5");
      idle("R10");
      win_rd(1, 4'h0, "R5");
      // R6: pair on empty stack underflows then pushes
      do_both(16'h7777, "R6");
      read_all("R6");

      // R7: clamp of an oversize restore, then a full-stack pair
      win_wr(1, 4'h0, 16'd200, "R7");
      win_rd(1, 4'h0, "R7");
      do_both(16'h4242, "R6");
      read_all("R6");

      // R8: restore a fresh image through the window
      for (int i = 0; i < D; i++) win_wr(1, AW'(8 + i), val(i + 20), "R8");
      read_all("R8");

      // R9: user accesses are rejected and change nothing
      win_wr(0, 4'h0, 16'd2, "R9");
      win_wr(0, 4'h9, 16'hFFFF, "R9");
      win_rd(0, 4'h0, "R9");
      win_rd(0, 4'hA, "R9");
      idle("R10");
      read_all("R9");

      // Sweep every restored depth: a return then a call against the model
      for (int d = 0; d <= D; d++) begin
         for (int i = 0; i < D; i++) win_wr(1, AW'(8 + i), val(i + 40 + d), "R8");
         win_wr(1, 4'h0, W'(d), "R7");
         win_rd(1, 4'h0, "R7");
         if (d > 0) do_ret(val(d - 1 + 40 + d), "R2");
         else do_ret(16'h3333, "R5");
         do_call(val(d), "R1");
         do_call(val(d + 1), "R4");
         win_wr(1, 4'h0, W'(D), "R7");
         do_call(16'h9999, "R4");
         do_ret(16'h9999, "R3");
         read_all("R8");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule